// File: doc/BRIEF.md
# Quadrature Phase-Counting Timer Channel

This block is one 16-bit timer channel. In its default mode the counter advances by one on every clock cycle in which a prescaled tick input is high. When the phase-mode bit of its mode register is set, the counter becomes an up/down counter driven by two external quadrature inputs, A and B. Each level change on either input moves the count by one, so a full quadrature cycle gives four counts. The direction of each count comes from the level of the other input.

Both external inputs pass through a synchroniser before edge detection. A cycle in which both synchronised inputs change together is an invalid transition and is not counted. A mode register holds the phase-mode enable, an overflow-condition select and five PWM enable bits, which go out to neighbouring channels. A sticky overflow flag records counter wraps. The flag is cleared by reading it as 1 and then writing 0 to it. The bus is a simple single-cycle read/write port with a 2-bit word address. Reads are combinational.

Top module: `quad_timer_chan`

## Requirements
- R1: After reset the mode register reads 0x0080, the counter reads 0 and the status word reads 0. Address 0 is the mode register, address 1 is the counter and address 2 is the status word, whose bit 0 is the overflow flag.
- R2: A write to address 0 stores bits 6..0 and ignores bit 7. A read of address 0 returns bit 7 as 1 and bits 6..0 as stored. Bit 6 is the phase-mode enable and bit 5 is the overflow select. Bits 4..0 are driven on `pwm_en[4:0]`.
- R3: With phase mode off, the counter increments by one at each clock edge where `tick_in` is high. Activity on the quadrature inputs has no effect on it.
- R4: With phase mode on, the counter increments when A rises while B is low, B rises while A is high, A falls while B is high, or B falls while A is low.
- R5: With phase mode on, the counter decrements when A rises while B is high, B rises while A is low, A falls while B is low, or B falls while A is high.
- R6: If both synchronised inputs change in the same cycle, the count is left unchanged.
- R7: With phase mode on, `tick_in` has no effect on the counter.
- R8: A single input change first sampled at clock edge k becomes visible in the counter after edge k+2 and not after edge k+1.
- R9: With overflow select at 1, the flag sets on an up-count wrap from 0xFFFF to 0x0000 and does not set on a down-count wrap.
- R10: With overflow select at 0, the flag sets on either an up-count wrap or a down-count wrap from 0x0000 to 0xFFFF.
- R11: Writing 0 to status bit 0 clears the flag only if the status word was read with the flag at 1 since the flag last cleared. Otherwise the write has no effect.
- R12: A bus write to the counter takes priority over a count event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms the flag clear) |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| tick_in | input | 1 | Prescaled internal count tick |
| phase_a | input | 1 | External quadrature input A (asynchronous) |
| phase_b | input | 1 | External quadrature input B (asynchronous) |
| pwm_en | output | 5 | PWM enable bits from the mode register |
| ovf_flag | output | 1 | Overflow flag |

## Verification
A tick, a bus counter write or a register write takes effect at the edge on which it is presented. A quadrature input change lands in the count two edges after the edge that first samples it. The bench drives inputs at falling edges and waits three full clocks after each quadrature change before reading the counter, which lies beyond the two-edge latency. The latency check itself samples after the first and second following edges. The flag is read one clock after the step that wraps the counter, because the wrap event and the flag update share an edge.

// File: rtl/qt_pkg.sv
package qt_pkg;
  typedef enum logic [1:0] {STEP_NONE, STEP_UP, STEP_DN} step_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int MODE_W      = 8;
  localparam int PWM_CH      = 5;
  localparam int BIT_PHASE   = 6;
  localparam int BIT_OVF_SEL = 5;

  // One input changed: up if the new A differs from B after an A change,
  // or the new B equals A after a B change.
  function automatic step_e quad_decode(input logic pa, input logic pb,
                                        input logic na, input logic nb);
    logic a_chg, b_chg;
    a_chg = pa ^ na;
    b_chg = pb ^ nb;
    if (a_chg && !b_chg) return (na ^ nb) ? STEP_UP : STEP_DN;
    if (b_chg && !a_chg) return (na ^ nb) ? STEP_DN : STEP_UP;
    return STEP_NONE;
  endfunction
endpackage

// File: rtl/qt_in_sync.sv
module qt_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  for (genvar i = 0; i < STAGES; i++) begin : g_st
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sr[0] <= 1'b0;
        else        sr[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) sr[i] <= 1'b0;
        else        sr[i] <= sr[i-1];
      end
    end
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/qt_phase_dec.sv
module qt_phase_dec
  import qt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_a,
  input  logic phase_b,
  output logic step_up,
  output logic step_dn,
  output logic both_chg
);
  logic a_s, b_s, a_q, b_q;
  step_e step;

  qt_in_sync #(.STAGES(SYNC_STAGES)) u_sync_a (.clk(clk), .rst_n(rst_n), .din(phase_a), .dout(a_s));
  qt_in_sync #(.STAGES(SYNC_STAGES)) u_sync_b (.clk(clk), .rst_n(rst_n), .din(phase_b), .dout(b_s));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_s;
      b_q <= b_s;
    end
  end

  always_comb step = quad_decode(a_q, b_q, a_s, b_s);

  assign step_up  = (step == STEP_UP);
  assign step_dn  = (step == STEP_DN);
  assign both_chg = (a_q ^ a_s) && (b_q ^ b_s);

  // R6
  step_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn, both_chg}));
endmodule

// File: rtl/qt_counter.sv
module qt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             wrap_up,
  output logic             wrap_dn
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic up, input logic dn);
    if (up) return c + CNT_ONE;
    if (dn) return c - CNT_ONE;
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else           count <= next_count(count, inc, dec);
  end

  assign wrap_up = !load && inc && (count == CNT_MAX);
  assign wrap_dn = !load && dec && !inc && (count == '0);

  // R12
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));
  // R4
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && inc) |=> count == $past(count) + CNT_ONE);
  // R5
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && dec && !inc) |=> count == $past(count) - CNT_ONE);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !inc && !dec) |=> $stable(count));
endmodule

// File: rtl/qt_ctrl_regs.sv
module qt_ctrl_regs
  import qt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mode,
  input  logic [6:0]        mode_wdata,
  input  logic              wr_stat,
  input  logic              stat_wbit,
  input  logic              rd_stat,
  input  logic              wrap_up,
  input  logic              wrap_dn,
  output logic              phase_en,
  output logic              ovf_sel,
  output logic [PWM_CH-1:0] pwm_en,
  output logic [MODE_W-1:0] mode_byte,
  output logic              ovf_flag
);
  logic [6:0] mode_q;
  logic       armed;
  logic       ovf_set, ovf_clr;

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= '0;
    else if (wr_mode) mode_q <= mode_wdata;
  end

  assign phase_en  = mode_q[BIT_PHASE];
  assign ovf_sel   = mode_q[BIT_OVF_SEL];
  assign pwm_en    = mode_q[PWM_CH-1:0];
  assign mode_byte = {1'b1, mode_q};

  assign ovf_set = wrap_up || (wrap_dn && !ovf_sel);
  assign ovf_clr = wr_stat && !stat_wbit && armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (ovf_set)      ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
      if (ovf_clr)                  armed <= 1'b0;
      else if (rd_stat && ovf_flag) armed <= 1'b1;
    end
  end

  // R10
  up_wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_up |=> ovf_flag);
  // R9
  dn_wrap_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sel && wrap_dn && !ovf_flag && !wrap_up) |=> !ovf_flag);
  // R11
  unarmed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !armed) |=> ovf_flag);
endmodule

// File: rtl/quad_timer_chan.sv
module quad_timer_chan
  import qt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              tick_in,
  input  logic              phase_a,
  input  logic              phase_b,
  output logic [PWM_CH-1:0] pwm_en,
  output logic              ovf_flag
);
  logic             step_up, step_dn, both_chg;
  logic             phase_en, ovf_sel;
  logic             cnt_load, cnt_inc, cnt_dec;
  logic             wrap_up, wrap_dn;
  logic [CNT_W-1:0] count;
  logic [MODE_W-1:0] mode_byte;
  logic             wr_mode, wr_stat, rd_stat;

  assign wr_mode  = bus_wr && (bus_addr == ADDR_MODE);
  assign cnt_load = bus_wr && (bus_addr == ADDR_CNT);
  assign wr_stat  = bus_wr && (bus_addr == ADDR_STAT);
  assign rd_stat  = bus_rd && (bus_addr == ADDR_STAT);

  qt_phase_dec #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
    .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
    .step_up(step_up), .step_dn(step_dn), .both_chg(both_chg)
  );

  assign cnt_inc = phase_en ? step_up : tick_in;
  assign cnt_dec = phase_en && step_dn;

  qt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(bus_wdata),
    .inc(cnt_inc), .dec(cnt_dec), .count(count),
    .wrap_up(wrap_up), .wrap_dn(wrap_dn)
  );

  qt_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_mode(wr_mode), .mode_wdata(bus_wdata[6:0]),
    .wr_stat(wr_stat), .stat_wbit(bus_wdata[0]), .rd_stat(rd_stat),
    .wrap_up(wrap_up), .wrap_dn(wrap_dn),
    .phase_en(phase_en), .ovf_sel(ovf_sel), .pwm_en(pwm_en),
    .mode_byte(mode_byte), .ovf_flag(ovf_flag)
  );

  always_comb begin
    unique case (bus_addr)
      ADDR_MODE: bus_rdata = CNT_W'(mode_byte);
      ADDR_CNT:  bus_rdata = count;
      ADDR_STAT: bus_rdata = CNT_W'(ovf_flag);
      default:   bus_rdata = '0;
    endcase
  end

  // R6
  both_chg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_en && both_chg && !cnt_load) |=> $stable(count));
  // R7
  tick_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_en && !step_up && !step_dn && !cnt_load) |=> $stable(count));
endmodule

// File: tb/quad_timer_chan_tb_top.sv
module quad_timer_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        tick_in = 1'b0, phase_a = 1'b0, phase_b = 1'b0;
  logic [4:0]  pwm_en;
  logic        ovf_flag;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] exp_cnt;
  logic [15:0] rv;

  always #5 clk = ~clk;

  quad_timer_chan dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_in(tick_in), .phase_a(phase_a), .phase_b(phase_b),
    .pwm_en(pwm_en), .ovf_flag(ovf_flag)
  );

  // Position on the quadrature cycle: 00->0, A only->1, both->2, B only->3.
  function automatic int gray_pos(input logic a, input logic b);
    return {b, a ^ b};
  endfunction

  function automatic int quad_delta(input logic pa, input logic pb,
                                    input logic na, input logic nb);
    int d;
    d = (gray_pos(na, nb) - gray_pos(pa, pb) + 4) % 4;
    if (d == 1) return 1;
    if (d == 3) return -1;
    return 0;
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Drive one quadrature change and let it settle through the pipeline.
  task automatic qstep(input bit up);
    @(negedge clk);
    if ((phase_a == phase_b) == up) phase_a = ~phase_a;
    else                            phase_b = ~phase_b;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_flag();
    bus_read(2'd2, rv);
    if (rv[0]) bus_write(2'd2, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(2'd0, rv); check("R1 mode", rv, 16'h0080);
    peek(2'd1, rv); check("R1 count", rv, 16'h0000);
    peek(2'd2, rv); check("R1 status", rv, 16'h0000);

    // R2 mode register
    bus_write(2'd0, 16'h0015);
    peek(2'd0, rv); check("R2 read", rv, 16'h0095);
    check("R2 pwm_en", {11'd0, pwm_en}, 16'h0015);
    bus_write(2'd0, 16'h0080);
    peek(2'd0, rv); check("R2 bit7 ignored", rv, 16'h0080);

    // R3 normal mode: ticks count, quadrature ignored
    bus_write(2'd1, 16'h0000);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); tick_in = 1'b1; phase_a = ~phase_a;
      @(negedge clk); tick_in = 1'b0; phase_b = ~phase_b;
    end
    @(negedge clk); tick_in = 1'b1;
    repeat (3) @(negedge clk);
    tick_in = 1'b0;
    repeat (3) @(negedge clk);
    peek(2'd1, rv); check("R3 tick count", rv, 16'd8);

    // R12 bus write beats a tick in the same cycle
    @(negedge clk);
    tick_in = 1'b1; bus_addr = 2'd1; bus_wdata = 16'h1234; bus_wr = 1'b1;
    @(negedge clk);
    tick_in = 1'b0; bus_wr = 1'b0;
    peek(2'd1, rv); check("R12 write priority", rv, 16'h1234);

    // Phase mode, overflow select 0
    bus_write(2'd0, 16'h0040);
    bus_write(2'd1, 16'd100);
    for (int i = 0; i < 4; i++) qstep(1'b1);
    peek(2'd1, rv); check("R4 up steps", rv, 16'd104);
    for (int i = 0; i < 6; i++) qstep(1'b0);
    peek(2'd1, rv); check("R5 down steps", rv, 16'd98);

    // R6 both change together
    @(negedge clk); phase_a = ~phase_a; phase_b = ~phase_b;
    repeat (3) @(negedge clk);
    peek(2'd1, rv); check("R6 both change", rv, 16'd98);

    // R7 tick ignored in phase mode
    @(negedge clk); tick_in = 1'b1;
    repeat (4) @(negedge clk); tick_in = 1'b0;
    peek(2'd1, rv); check("R7 tick ignored", rv, 16'd98);

    // R8 latency: first sampling edge k, visible after k+2
    @(negedge clk);
    if (phase_a == phase_b) phase_a = ~phase_a; else phase_b = ~phase_b;
    @(negedge clk);               // edge k passed
    @(negedge clk); #1;           // edge k+1 passed
    bus_addr = 2'd1; #1 check("R8 not yet", bus_rdata, 16'd98);
    @(negedge clk); #1;           // edge k+2 passed
    check("R8 visible", bus_rdata, 16'd99);

    // R4 R5 R6 R7 random bursts against the gray-position model
    exp_cnt = 16'd99;
    for (int burst = 0; burst < 25; burst++) begin
      for (int c = 0; c < 20; c++) begin
        logic na, nb;
        int sel;
        @(negedge clk);
        sel = $urandom_range(0, 9);
        na = phase_a; nb = phase_b;
        if (sel < 4)      na = ~na;
        else if (sel < 8) nb = ~nb;
        else if (sel == 8) begin na = ~na; nb = ~nb; end
        exp_cnt = exp_cnt + 16'(quad_delta(phase_a, phase_b, na, nb));
        phase_a = na; phase_b = nb;
        tick_in = 1'($urandom_range(0, 1));
      end
      @(negedge clk); tick_in = 1'b0;
      repeat (3) @(negedge clk);
      peek(2'd1, rv); check("R4/R5 random burst", rv, exp_cnt);
    end

    // R10 select 0: both wraps set the flag
    clear_flag();
    peek(2'd2, rv); check("R11 flag cleared", rv, 16'h0000);
    bus_write(2'd1, 16'h0000);
    qstep(1'b0);
    peek(2'd1, rv); check("R10 down wrap value", rv, 16'hFFFF);
    peek(2'd2, rv); check("R10 down wrap flag", rv, 16'h0001);
    clear_flag();
    bus_write(2'd1, 16'hFFFF);
    qstep(1'b1);
    peek(2'd1, rv); check("R10 up wrap value", rv, 16'h0000);
    peek(2'd2, rv); check("R10 up wrap flag", rv, 16'h0001);

    // R11 clear needs a prior read as 1
    bus_write(2'd2, 16'h0000);
    peek(2'd2, rv); check("R11 unarmed write", rv, 16'h0001);
    bus_write(2'd2, 16'h0001);
    bus_read(2'd2, rv); check("R11 read as 1", rv, 16'h0001);
    bus_write(2'd2, 16'h0000);
    peek(2'd2, rv); check("R11 armed clear", rv, 16'h0000);

    // R9 select 1: only the up wrap sets the flag
    bus_write(2'd0, 16'h0060);
    bus_write(2'd1, 16'h0000);
    qstep(1'b0);
    peek(2'd1, rv); check("R9 down wrap value", rv, 16'hFFFF);
    peek(2'd2, rv); check("R9 down wrap no flag", rv, 16'h0000);
    qstep(1'b1);
    peek(2'd2, rv); check("R9 up wrap flag", rv, 16'h0001);
    peek(2'd0, rv); check("R2 mode readback", rv, 16'h00E0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule